// File: doc/BRIEF.md
# Fractional Baud-Tick Divider

This block derives the 16x oversampling enable for an asynchronous serial port from a 48 MHz reference clock. It divides the reference by a programmable ratio with a 14-bit whole part and a 3-bit fraction counted in eighths. The output is a single-cycle enable. A non-integer ratio is reached by making some output periods one reference cycle longer than the rest. A 3-bit phase accumulator decides which periods are stretched, so that over eight periods the average length equals whole plus fraction/8.

The divisor is written by presenting both fields together with a one-cycle load strobe. The new ratio is held aside and takes over only where one period ends and the next begins. A period that is running is never cut short or lengthened by a load. Ratios run from 1.0, which gives an enable on every reference cycle (3 Mbaud at 16x oversampling), up to 16383.875, which lands near 183 baud. A whole part of zero is read as one.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is high, tick_o is 0. The divisor after reset is whole 1, fraction 0, so tick_o is high in every cycle from the first cycle after the first clock edge that sees reset low.
- R2: With fraction 0 and whole part N (1 to 16383), tick_o pulses are exactly N cycles apart.
- R3: A whole part of 0 behaves exactly like a whole part of 1.
- R4: With fraction f (div_frac_i is f in eighths) and effective whole part N, the k-th period after the divisor takes effect lasts N+1 cycles when floor(k*f/8) > floor((k-1)*f/8), and N cycles otherwise. Eight periods therefore total 8N+f cycles.
- R5: When a period is at least two cycles long, tick_o stays high for exactly one cycle.
- R6: A load given in a cycle where tick_o is low does not change the period in progress. The new divisor governs the period that begins after the next tick_o.
- R7: A load given in a cycle where tick_o is high governs the period that begins right after that tick_o.
- R8: When several loads arrive within one period, only the last of them takes effect.
- R9: The fractional phase restarts at zero whenever a loaded divisor takes effect, so stretches caused by an earlier divisor do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | One-cycle strobe that captures div_whole_i and div_frac_i |
| div_whole_i | input | 14 | Whole part of the divide ratio (0 is read as 1) |
| div_frac_i | input | 3 | Fractional part of the divide ratio, in eighths |
| tick_o | output | 1 | One-cycle 16x baud enable |

## Verification
Two things can happen at the same period boundary: a divisor hand-over and a fractional stretch. When a load coincides with tick_o, the new ratio has to be chosen, the accumulator has to restart, and the carry has to be decided from the new fraction, all at the same clock edge. The bench provokes this by raising load_i exactly in tick cycles, including cases where the previous fraction had left a non-zero phase. It then compares each following period length with the floor formula of R4, computed from the newly loaded divisor alone.

// File: rtl/baud_pkg.sv
package baud_pkg;

    parameter int unsigned BAUD_INT_W  = 14;
    parameter int unsigned BAUD_FRAC_W = 3;

    typedef logic [BAUD_INT_W-1:0]  baud_int_t;
    typedef logic [BAUD_FRAC_W-1:0] baud_frac_t;

    typedef struct packed {
        baud_int_t  whole;
        baud_frac_t eighths;
    } baud_div_t;

    typedef struct packed {
        logic       carry;
        baud_frac_t phase;
    } baud_acc_t;

    localparam baud_div_t BAUD_DIV_RESET = '{whole: baud_int_t'(1), eighths: '0};

    function automatic baud_int_t baud_eff_whole(input baud_int_t w);
        return (w == '0) ? baud_int_t'(1) : w;
    endfunction

endpackage

// File: rtl/baud_div_hold.sv
module baud_div_hold
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  baud_div_t div_i,
    input  logic      boundary_i,
    output baud_div_t sel_o,
    output baud_div_t applied_o,
    output logic      fresh_o
);
    baud_div_t pend_q;
    logic      pend_vld_q;
    baud_div_t applied_q;

    // Divisor for the period that starts at the next boundary.
    always_comb begin
        if (load_i)
            sel_o = div_i;
        else if (pend_vld_q)
            sel_o = pend_q;
        else
            sel_o = applied_q;
    end

    assign fresh_o   = load_i | pend_vld_q;
    assign applied_o = applied_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= BAUD_DIV_RESET;
            pend_vld_q <= 1'b0;
            applied_q  <= BAUD_DIV_RESET;
        end else if (boundary_i) begin
            applied_q  <= sel_o;
            pend_vld_q <= 1'b0;
        end else if (load_i) begin
            pend_q     <= div_i;
            pend_vld_q <= 1'b1;
        end
    end
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_i,
    input  logic       restart_i,
    input  baud_frac_t frac_i,
    output logic       carry_o
);
    baud_frac_t phase_q;
    baud_acc_t  sum;

    always_comb begin
        sum     = {1'b0, (restart_i ? baud_frac_t'(0) : phase_q)} + {1'b0, frac_i};
        carry_o = sum.carry;
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (step_i)
            phase_q <= sum.phase;
    end
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  baud_int_t whole_i,
    input  logic      stretch_i,
    output logic      tick_o
);
    baud_int_t cnt_q;
    logic      run_q;
    baud_int_t reload;

    assign tick_o = run_q && (cnt_q == '0);
    assign reload = whole_i - baud_int_t'(1) + baud_int_t'(stretch_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= 1'b1;
            if (tick_o)
                cnt_q <= reload;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - baud_int_t'(1);
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import baud_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_i,
    input  logic [BAUD_INT_W-1:0]  div_whole_i,
    input  logic [BAUD_FRAC_W-1:0] div_frac_i,
    output logic                   tick_o
);
    baud_div_t req_div;
    baud_div_t sel_div;
    baud_div_t applied_div;
    baud_int_t eff_whole;
    logic      fresh;
    logic      stretch;
    logic      tick;

    assign req_div   = '{whole: div_whole_i, eighths: div_frac_i};
    assign eff_whole = baud_eff_whole(sel_div.whole);
    assign tick_o    = tick;

    baud_div_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .div_i      (req_div),
        .boundary_i (tick),
        .sel_o      (sel_div),
        .applied_o  (applied_div),
        .fresh_o    (fresh)
    );

    baud_frac_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .step_i    (tick),
        .restart_i (fresh),
        .frac_i    (sel_div.eighths),
        .carry_o   (stretch)
    );

    baud_period_cnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .whole_i   (eff_whole),
        .stretch_i (stretch),
        .tick_o    (tick)
    );
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk
    import baud_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_o,
    input baud_int_t  sel_whole,
    input baud_frac_t sel_frac,
    input baud_div_t  applied
);
    logic [BAUD_INT_W+1:0] gap_q;
    logic [BAUD_INT_W+1:0] exp_n_q;
    baud_frac_t            exp_f_q;
    logic                  armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            exp_n_q <= '0;
            exp_f_q <= '0;
            armed_q <= 1'b0;
        end else if (tick_o) begin
            gap_q   <= 1;
            exp_n_q <= {2'b00, baud_eff_whole(sel_whole)};
            exp_f_q <= sel_frac;
            armed_q <= 1'b1;
        end else begin
            gap_q   <= gap_q + 1'b1;
        end
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk) rst |=> !tick_o);

    a_r2_exact_integral: assert property (@(posedge clk) disable iff (rst)
        (armed_q && tick_o && exp_f_q == '0) |-> gap_q == exp_n_q);

    a_r4_period_len: assert property (@(posedge clk) disable iff (rst)
        (armed_q && tick_o) |-> (gap_q == exp_n_q || gap_q == exp_n_q + 1'b1));

    a_r3_zero_whole: assert property (@(posedge clk) disable iff (rst)
        (tick_o && sel_whole == '0 && sel_frac == '0) |=> tick_o);

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (tick_o && baud_eff_whole(sel_whole) != baud_int_t'(1)) |=> !tick_o);

    a_r6_applied_stable: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(applied));
endmodule

bind frac_baud_gen frac_baud_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_o    (tick_o),
    .sel_whole (sel_div.whole),
    .sel_frac  (sel_div.eighths),
    .applied   (applied_div)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [13:0] div_whole_i = '0;
    logic [2:0]  div_frac_i = '0;
    logic        tick_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    frac_baud_gen dut (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .div_whole_i (div_whole_i),
        .div_frac_i  (div_frac_i),
        .tick_o      (tick_o)
    );

    always #4 clk = ~clk;

    // {whole, fraction, expected sum of eight periods}
    localparam int NV = 10;
    localparam int VEC [NV][3] = '{
        '{1, 0, 8}, '{2, 0, 16}, '{5, 0, 40}, '{3, 1, 25}, '{3, 4, 28},
        '{3, 7, 31}, '{6, 3, 51}, '{0, 0, 8},  '{0, 5, 13}, '{1, 7, 15}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int w, input int f, input int k);
        int n = (w == 0) ? 1 : w;
        return n + ((((k * f) / 8) != (((k - 1) * f) / 8)) ? 1 : 0);
    endfunction

    task automatic wait_tick();
        while (!tick_o) @(negedge clk);
    endtask

    task automatic load_at_tick(input int w, input int f);
        wait_tick();
        load_i = 1'b1;
        div_whole_i = 14'(w);
        div_frac_i = 3'(f);
        @(posedge clk);
        #1 load_i = 1'b0;
    endtask

    task automatic measure_gap(output int n);
        @(negedge clk);
        n = 1;
        while (!tick_o) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        while (!done && cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int g;
        int sum;
        int n;
        // R1: quiet while in reset, then tick on every cycle
        repeat (3) @(negedge clk);
        chk("R1 tick low in reset", int'(tick_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first tick after reset", int'(tick_o), 1);
        @(negedge clk);
        chk("R1 default divisor 1", int'(tick_o), 1);

        // Table: R2, R3, R4, R7 (each load lands in a tick cycle)
        for (int v = 0; v < NV; v++) begin
            load_at_tick(VEC[v][0], VEC[v][1]);
            sum = 0;
            for (int k = 1; k <= 8; k++) begin
                measure_gap(g);
                sum += g;
                chk($sformatf("R4/R7 vec%0d period%0d", v, k), g, exp_len(VEC[v][0], VEC[v][1], k));
            end
            chk($sformatf("R2/R3/R4 vec%0d sum", v), sum, VEC[v][2]);
        end

        // R5: pulse is one cycle wide
        load_at_tick(4, 0);
        @(negedge clk);
        chk("R5 tick drops", int'(tick_o), 0);

        // R6: load mid-period does not disturb it
        load_at_tick(10, 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 3) begin
                load_i = 1'b1; div_whole_i = 14'd4; div_frac_i = 3'd0;
            end else begin
                load_i = 1'b0;
            end
        end while (!tick_o);
        load_i = 1'b0;
        chk("R6 old period kept", n, 10);
        measure_gap(g);
        chk("R6 new divisor next period", g, 4);

        // R8: last of several loads wins
        load_at_tick(10, 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 2) begin
                load_i = 1'b1; div_whole_i = 14'd7; div_frac_i = 3'd0;
            end else if (n == 4) begin
                load_i = 1'b1; div_whole_i = 14'd0; div_frac_i = 3'd0;
            end else begin
                load_i = 1'b0;
            end
        end while (!tick_o);
        load_i = 1'b0;
        chk("R8 running period", n, 10);
        measure_gap(g);
        chk("R8 last load wins (R3 zero as one)", g, 1);

        // R9: phase restarts when a new divisor takes effect
        load_at_tick(3, 7);
        for (int k = 1; k <= 3; k++) measure_gap(g);
        load_at_tick(3, 1);
        for (int k = 1; k <= 8; k++) begin
            measure_gap(g);
            chk($sformatf("R9 restart period%0d", k), g, (k == 8) ? 4 : 3);
        end

        // R2/R4 at the largest whole part
        load_at_tick(16383, 0);
        measure_gap(g);
        chk("R2 max whole", g, 16383);
        load_at_tick(16383, 4);
        measure_gap(g);
        chk("R4 max whole k1", g, 16383);
        measure_gap(g);
        chk("R4 max whole k2", g, 16384);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule